// File: doc/BRIEF.md
# Prescaled Match/Capture Timer

A 32-bit up-counter fed by a 32-bit prescaler. The count source is either every system clock cycle or the synchronized edges of an external count pin. Four compare channels watch the counter. When the counter steps onto a channel's value, that channel can do four things. It can set an interrupt flag. It can make the counter wrap to zero on the following step. It can halt counting. It can also change its own output pin: leave it alone, force it low, force it high or invert it. A separate capture pin, also synchronized, copies the counter into a snapshot register on a chosen edge. That copy can raise an interrupt too.

Software reaches everything through one flat register port. A write takes effect at the clock edge on which `reg_wr` is high. The read port is combinational from `reg_addr`. Counting is governed by a three-state run machine:

- `ST_IDLE`: stopped, and the counter holds its value.
- `ST_RUN`: counting.
- `ST_HOLD`: the counter and the prescaler are forced to zero.

The machine has these transitions:

- A CTRL write with the hold bit set goes to `ST_HOLD`.
- A CTRL write with hold clear and run set goes to `ST_RUN`.
- A CTRL write with both bits clear goes to `ST_IDLE`.
- In `ST_RUN`, a stop-enabled match goes to `ST_IDLE`.

Top module: `match_timer`

## Requirements
- R1: After reset the following all read zero: CTRL (address 0), COUNT (3), FLAGS (9), CAPVAL (8) and the pin state (6). The `match_out` and `irq` ports are low.
- R2: CTRL bit 0 set with bits 3:2 = 00 puts the timer in clock mode. Here the counter advances once every PRESC+1 cycles, where PRESC is address 1. The prescaler count is readable at address 2, and COUNT can be written directly.
- R3: CTRL bits 3:2 select the count source: 00 clock, 01 rising edges of `cnt_in`, 10 falling edges, 11 both edges. In the edge modes, each synchronized edge is one prescaler step and clock cycles do not count.
- R4: A channel matches when a count step makes COUNT equal its match register (addresses 12+i). If MCTRL (address 4) bit 3i is set, FLAGS bit i is set and `irq` goes high. With that bit clear, no flag is set.
- R5: If MCTRL bit 3i+1 is set and COUNT equals match value N, the next count step loads zero. The counter then cycles through N+1 values.
- R6: If MCTRL bit 3i+2 is set, a match returns the run machine to `ST_IDLE`, so CTRL bit 0 reads 0 and COUNT holds the match value. Stop takes priority over wrap.
- R7: PINACT (address 5) bits 2i+1:2i set the action of pin i on a match: 00 keep, 01 low, 10 high, 11 toggle. A write to address 6 loads the pins directly.
- R8: CAPCTRL (address 7) is laid out as follows:
  - bit 0 enables capture on rising edges of `cap_in`.
  - bit 1 enables capture on falling edges.
  - bit 2 sets FLAGS bit 4 when a capture happens.
  
  An edge that is not enabled leaves CAPVAL unchanged. A capture lands in CAPVAL at the third rising clock edge after `cap_in` changes.
- R9: Writing 1 to a FLAGS bit clears it, and writing 0 leaves it set. `irq` is the OR of all FLAGS bits.
- R10: CTRL bit 1 holds COUNT and the prescaler count at zero, and CTRL then reads 2. Releasing the bit with bit 0 set resumes counting from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| cnt_in | input | 1 | External count source (asynchronous) |
| cap_in | input | 1 | Capture trigger (asynchronous) |
| match_out | output | 4 | One output pin per match channel |
| irq | output | 1 | Interrupt, OR of the flags |

## Verification
Each count step updates COUNT, the flags, the pins and the stop state at the same clock edge. With prescale P, the bench therefore reads COUNT exactly N cycles after the enabling write and expects floor(N/(P+1)) steps, wrapped modulo N+1 when wrap is enabled. Inputs on `cnt_in` and `cap_in` pass through two synchronizer flops and an edge flop. For this reason the capture check samples after two edges, expecting the old value, and again after three, expecting the new one. Edge-count tests wait at least four cycles after the last edge before reading.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'd0,
        PIN_LOW    = 2'd1,
        PIN_HIGH   = 2'd2,
        PIN_TOGGLE = 2'd3
    } pin_act_e;

    typedef enum logic [1:0] {
        SRC_CLK  = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_BOTH = 2'd3
    } cnt_src_e;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL       = 4'd0;
    localparam logic [ADDR_W-1:0] A_PRESC      = 4'd1;
    localparam logic [ADDR_W-1:0] A_PCNT       = 4'd2;
    localparam logic [ADDR_W-1:0] A_COUNT      = 4'd3;
    localparam logic [ADDR_W-1:0] A_MCTRL      = 4'd4;
    localparam logic [ADDR_W-1:0] A_PINACT     = 4'd5;
    localparam logic [ADDR_W-1:0] A_PINST      = 4'd6;
    localparam logic [ADDR_W-1:0] A_CAPCTRL    = 4'd7;
    localparam logic [ADDR_W-1:0] A_CAPVAL     = 4'd8;
    localparam logic [ADDR_W-1:0] A_FLAGS      = 4'd9;
    localparam logic [ADDR_W-1:0] A_MATCH_BASE = 4'd12;

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] & ~prev_q;
    assign fall = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] pcount,
    output logic         tick
);
    logic [W-1:0] pcount_q;

    assign tick   = step && !clear && (pcount_q >= limit);
    assign pcount = pcount_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcount_q <= '0;
        end else if (clear) begin
            pcount_q <= '0;
        end else if (step) begin
            pcount_q <= tick ? '0 : pcount_q + 1'b1;
        end
    end

    // R2: a step below the limit advances the prescaler by one
    p_prescale_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && (pcount_q < limit)) |=> (pcount_q == $past(pcount_q) + 1'b1));

    // R2: a terminal step wraps the prescaler to zero
    p_prescale_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (pcount_q == '0));

endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch
    import timer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt_q,
    input  logic [W-1:0] cnt_nxt,
    input  logic [W-1:0] match_val,
    input  pin_act_e     act,
    input  logic         rst_en,
    input  logic         pin_wr,
    input  logic         pin_wdata,
    output logic         hit,
    output logic         rst_req,
    output logic         pin
);
    logic pin_q;

    assign hit     = tick && (cnt_nxt == match_val);
    assign rst_req = rst_en && (cnt_q == match_val);
    assign pin     = pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (pin_wr) begin
            pin_q <= pin_wdata;
        end else if (hit) begin
            unique case (act)
                PIN_KEEP:   pin_q <= pin_q;
                PIN_LOW:    pin_q <= 1'b0;
                PIN_HIGH:   pin_q <= 1'b1;
                PIN_TOGGLE: pin_q <= ~pin_q;
                default:    pin_q <= pin_q;
            endcase
        end
    end

    // R7: each pin action seen one cycle after the match
    p_pin_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pin_wr && act == PIN_HIGH) |=> pin_q);
    p_pin_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pin_wr && act == PIN_LOW) |=> !pin_q);
    p_pin_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !pin_wr && act == PIN_TOGGLE) |=> (pin_q != $past(pin_q)));
    p_pin_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !pin_wr) |=> $stable(pin_q));

endmodule

// File: rtl/match_timer.sv
module match_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_MATCH   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [CNT_W-1:0]    reg_wdata,
    output logic [CNT_W-1:0]    reg_rdata,
    input  logic                cnt_in,
    input  logic                cap_in,
    output logic [NUM_MATCH-1:0] match_out,
    output logic                irq
);
    localparam int FLAG_W  = NUM_MATCH + 1;
    localparam int MCTRL_W = 3 * NUM_MATCH;
    localparam int PACT_W  = 2 * NUM_MATCH;
    localparam int CAP_BIT = NUM_MATCH;

    run_state_e              state_q, state_d;
    cnt_src_e                src_q;
    logic [CNT_W-1:0]        presc_q, pcount, count_q, cnt_nxt, cap_q;
    logic [MCTRL_W-1:0]      mctrl_q;
    logic [PACT_W-1:0]       pinact_q;
    logic [2:0]              capcfg_q;
    logic [FLAG_W-1:0]       flags_q, flag_set, flag_clr;
    logic [CNT_W-1:0]        match_q [NUM_MATCH];
    logic [NUM_MATCH-1:0]    hit, rst_req, stop_hit, irq_hit, wr_match;

    logic wr_ctrl, wr_presc, wr_count, wr_mctrl, wr_pinact, wr_pinst, wr_capctrl, wr_flags;
    logic ext_rise, ext_fall, cap_rise, cap_fall, cap_evt;
    logic src_edge, pre_step, presc_clear, cnt_zero, tick;

    // register write decode
    assign wr_ctrl    = reg_wr && (reg_addr == A_CTRL);
    assign wr_presc   = reg_wr && (reg_addr == A_PRESC);
    assign wr_count   = reg_wr && (reg_addr == A_COUNT);
    assign wr_mctrl   = reg_wr && (reg_addr == A_MCTRL);
    assign wr_pinact  = reg_wr && (reg_addr == A_PINACT);
    assign wr_pinst   = reg_wr && (reg_addr == A_PINST);
    assign wr_capctrl = reg_wr && (reg_addr == A_CAPCTRL);
    assign wr_flags   = reg_wr && (reg_addr == A_FLAGS);

    // input synchronizers
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst_n(rst_n), .din(cnt_in), .rise(ext_rise), .fall(ext_fall)
    );
    tmr_edge_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst_n(rst_n), .din(cap_in), .rise(cap_rise), .fall(cap_fall)
    );

    always_comb begin
        unique case (src_q)
            SRC_CLK:  src_edge = 1'b1;
            SRC_RISE: src_edge = ext_rise;
            SRC_FALL: src_edge = ext_fall;
            SRC_BOTH: src_edge = ext_rise | ext_fall;
            default:  src_edge = 1'b0;
        endcase
    end

    // run machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // run machine: next state
    always_comb begin
        state_d = state_q;
        if (wr_ctrl) begin
            if (reg_wdata[1])      state_d = ST_HOLD;
            else if (reg_wdata[0]) state_d = ST_RUN;
            else                   state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_RUN:  if (|stop_hit) state_d = ST_IDLE;
                ST_IDLE: state_d = ST_IDLE;
                ST_HOLD: state_d = ST_HOLD;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // run machine: outputs
    always_comb begin
        pre_step    = 1'b0;
        presc_clear = 1'b0;
        cnt_zero    = 1'b0;
        unique case (state_q)
            ST_RUN:  pre_step = src_edge;
            ST_HOLD: begin
                presc_clear = 1'b1;
                cnt_zero    = 1'b1;
            end
            ST_IDLE: pre_step = 1'b0;
            default: pre_step = 1'b0;
        endcase
    end

    tmr_prescaler #(.W(CNT_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(presc_clear), .step(pre_step),
        .limit(presc_q), .pcount(pcount), .tick(tick)
    );

    assign cnt_nxt = (|rst_req) ? '0 : count_q + 1'b1;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_MATCH; gi++) begin : g_ch
            assign wr_match[gi] = reg_wr && (reg_addr == A_MATCH_BASE + ADDR_W'(gi));
            assign irq_hit[gi]  = hit[gi] & mctrl_q[3*gi];
            assign stop_hit[gi] = hit[gi] & mctrl_q[3*gi+2];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            match_q[gi] <= '0;
                else if (wr_match[gi]) match_q[gi] <= reg_wdata;
            end

            tmr_match_ch #(.W(CNT_W)) u_ch (
                .clk(clk), .rst_n(rst_n), .tick(tick),
                .cnt_q(count_q), .cnt_nxt(cnt_nxt), .match_val(match_q[gi]),
                .act(pin_act_e'(pinact_q[2*gi +: 2])), .rst_en(mctrl_q[3*gi+1]),
                .pin_wr(wr_pinst), .pin_wdata(reg_wdata[gi]),
                .hit(hit[gi]), .rst_req(rst_req[gi]), .pin(match_out[gi])
            );
        end
    endgenerate

    assign cap_evt  = (cap_rise & capcfg_q[0]) | (cap_fall & capcfg_q[1]);
    assign flag_set = {cap_evt & capcfg_q[2], irq_hit};
    assign flag_clr = wr_flags ? reg_wdata[FLAG_W-1:0] : '0;

    // configuration, counter, capture and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q    <= SRC_CLK;
            presc_q  <= '0;
            count_q  <= '0;
            mctrl_q  <= '0;
            pinact_q <= '0;
            capcfg_q <= '0;
            cap_q    <= '0;
            flags_q  <= '0;
        end else begin
            if (wr_ctrl)    src_q    <= cnt_src_e'(reg_wdata[3:2]);
            if (wr_presc)   presc_q  <= reg_wdata;
            if (wr_mctrl)   mctrl_q  <= reg_wdata[MCTRL_W-1:0];
            if (wr_pinact)  pinact_q <= reg_wdata[PACT_W-1:0];
            if (wr_capctrl) capcfg_q <= reg_wdata[2:0];
            if (cnt_zero)      count_q <= '0;
            else if (wr_count) count_q <= reg_wdata;
            else if (tick)     count_q <= cnt_nxt;
            if (cap_evt)    cap_q    <= count_q;
            flags_q <= (flags_q & ~flag_clr) | flag_set;
        end
    end

    assign irq = |flags_q;

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL:    reg_rdata = CNT_W'({src_q, state_q == ST_HOLD, state_q == ST_RUN});
            A_PRESC:   reg_rdata = presc_q;
            A_PCNT:    reg_rdata = pcount;
            A_COUNT:   reg_rdata = count_q;
            A_MCTRL:   reg_rdata = CNT_W'(mctrl_q);
            A_PINACT:  reg_rdata = CNT_W'(pinact_q);
            A_PINST:   reg_rdata = CNT_W'(match_out);
            A_CAPCTRL: reg_rdata = CNT_W'(capcfg_q);
            A_CAPVAL:  reg_rdata = cap_q;
            A_FLAGS:   reg_rdata = CNT_W'(flags_q);
            default: begin
                for (int i = 0; i < NUM_MATCH; i++)
                    if (reg_addr == A_MATCH_BASE + ADDR_W'(i)) reg_rdata = match_q[i];
            end
        endcase
    end

    // R6: a stop-enabled match ends the run
    p_stop_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && |stop_hit && !wr_ctrl) |=> (state_q == ST_IDLE));

    // R6: a stopped counter keeps its value
    p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !wr_count) |=> $stable(count_q));

    // R5: wrap request on a step yields zero
    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && |rst_req && !wr_count) |=> (count_q == '0));

    // R10: hold forces the counter to zero
    p_hold_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> (count_q == '0));

    // R9: written ones clear their flags
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && ((reg_wdata[FLAG_W-1:0] & flag_set) == '0))
        |=> ((flags_q & $past(reg_wdata[FLAG_W-1:0])) == '0));

    // R8: snapshot changes only on an enabled edge
    p_cap_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_q));

    // R4: a flagged match raises irq
    p_irq_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_hit) |=> irq);

endmodule

// File: tb/match_timer_tb.sv
module match_timer_tb;

    localparam logic [3:0] T_CTRL = 4'd0, T_PRESC = 4'd1, T_PCNT = 4'd2, T_COUNT = 4'd3;
    localparam logic [3:0] T_MCTRL = 4'd4, T_PINACT = 4'd5, T_PINST = 4'd6, T_CAPCTRL = 4'd7;
    localparam logic [3:0] T_CAPVAL = 4'd8, T_FLAGS = 4'd9, T_MATCH0 = 4'd12;

    localparam int NV = 6;
    localparam logic [31:0] V_PR  [NV] = '{32'd0, 32'd3, 32'd1, 32'd0, 32'd1, 32'd2};
    localparam logic [31:0] V_M0  [NV] = '{32'hFFFF, 32'hFFFF, 32'hFFFF, 32'd4, 32'd2, 32'd5};
    localparam logic        V_RST [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
    localparam int          V_CYC [NV] = '{7, 10, 9, 12, 13, 22};
    localparam logic [31:0] V_EXP [NV] = '{32'd7, 32'd2, 32'd4, 32'd2, 32'd0, 32'd1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cnt_in = 1'b0;
    logic        cap_in = 1'b0;
    logic [3:0]  match_out;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    match_timer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_in(cnt_in),
        .cap_in(cap_in), .match_out(match_out), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulses(input int n);
        for (int k = 0; k < n; k++) begin
            cnt_in = 1'b1; idle(4);
            cnt_in = 1'b0; idle(4);
        end
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        rd(T_CTRL, rv);   check("R1 ctrl", rv, 0);
        rd(T_COUNT, rv);  check("R1 count", rv, 0);
        rd(T_FLAGS, rv);  check("R1 flags", rv, 0);
        rd(T_CAPVAL, rv); check("R1 capval", rv, 0);
        rd(T_PINST, rv);  check("R1 pins", rv, 0);
        check("R1 match_out", {28'd0, match_out}, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2 / R5: vector table of prescale, wrap and run length
        for (int v = 0; v < NV; v++) begin
            wr(T_CTRL, 32'd2);
            wr(T_PRESC, V_PR[v]);
            wr(T_MATCH0, V_M0[v]);
            wr(T_MCTRL, V_RST[v] ? 32'd2 : 32'd0);
            wr(T_CTRL, 32'd1);
            idle(V_CYC[v]);
            rd(T_COUNT, rv);
            check(V_RST[v] ? "R5 wrap period" : "R2 prescaled count", rv, V_EXP[v]);
        end

        // R2: prescaler count readback and direct count write
        wr(T_CTRL, 32'd2);
        wr(T_PRESC, 32'd3);
        wr(T_MCTRL, 32'd0);
        wr(T_CTRL, 32'd1);
        idle(10);
        rd(T_PCNT, rv);  check("R2 pcount", rv, 2);
        wr(T_CTRL, 32'd0);
        wr(T_COUNT, 32'd40);
        rd(T_COUNT, rv); check("R2 count write", rv, 40);

        // R6 / R4: stop wins over wrap, flag raised
        wr(T_PRESC, 32'd0);
        wr(T_CTRL, 32'd2);
        wr(T_MATCH0, 32'd5);
        wr(T_MCTRL, 32'd7);
        wr(T_CTRL, 32'd1);
        idle(20);
        rd(T_COUNT, rv); check("R6 stopped count", rv, 5);
        rd(T_CTRL, rv);  check("R6 run bit cleared", rv, 0);
        rd(T_FLAGS, rv); check("R4 match flag", rv, 1);
        check("R4 irq", {31'd0, irq}, 1);

        // R9: write-one-to-clear
        wr(T_FLAGS, 32'd0);
        rd(T_FLAGS, rv); check("R9 zero write keeps", rv, 1);
        wr(T_FLAGS, 32'd1);
        rd(T_FLAGS, rv); check("R9 one write clears", rv, 0);
        check("R9 irq low", {31'd0, irq}, 0);

        // R7: pin actions (ch0 keep, ch1 high, ch2 toggle, ch3 low)
        wr(T_CTRL, 32'd2);
        for (int i = 0; i < 4; i++) wr(T_MATCH0 + 4'(i), 32'd2);
        wr(T_MCTRL, 32'h20);
        wr(T_PINACT, 32'h78);
        wr(T_PINST, 32'h8);
        wr(T_CTRL, 32'd1);
        idle(10);
        check("R7 pins first match", {28'd0, match_out}, 32'h6);
        rd(T_PINST, rv); check("R7 pin readback", rv, 32'h6);
        rd(T_FLAGS, rv); check("R4 no flag without enable", rv, 0);
        wr(T_CTRL, 32'd2);
        wr(T_CTRL, 32'd1);
        idle(10);
        check("R7 pins second match", {28'd0, match_out}, 32'h2);

        // R3: edge-count modes
        wr(T_MCTRL, 32'd0);
        wr(T_PINACT, 32'd0);
        wr(T_CTRL, 32'd2);
        wr(T_CTRL, 32'd5);
        pulses(3);
        rd(T_COUNT, rv); check("R3 rising edges", rv, 3);
        wr(T_CTRL, 32'd2);
        wr(T_CTRL, 32'd9);
        pulses(3);
        rd(T_COUNT, rv); check("R3 falling edges", rv, 3);
        wr(T_CTRL, 32'd2);
        wr(T_CTRL, 32'd13);
        pulses(3);
        rd(T_COUNT, rv); check("R3 both edges", rv, 6);
        wr(T_CTRL, 32'd2);
        wr(T_PRESC, 32'd1);
        wr(T_CTRL, 32'd13);
        pulses(3);
        rd(T_COUNT, rv); check("R3 both edges prescaled", rv, 3);

        // R10: hold
        wr(T_PRESC, 32'd0);
        wr(T_CTRL, 32'd1);
        idle(5);
        wr(T_CTRL, 32'd3);
        idle(3);
        rd(T_COUNT, rv); check("R10 held count", rv, 0);
        rd(T_PCNT, rv);  check("R10 held pcount", rv, 0);
        rd(T_CTRL, rv);  check("R10 ctrl reads hold", rv, 2);
        wr(T_CTRL, 32'd1);
        idle(4);
        rd(T_COUNT, rv); check("R10 resume from zero", rv, 4);

        // R8: capture
        wr(T_CTRL, 32'd0);
        wr(T_COUNT, 32'h1234);
        wr(T_CAPCTRL, 32'd5);
        cap_in = 1'b1;
        idle(2);
        rd(T_CAPVAL, rv); check("R8 not yet captured", rv, 0);
        idle(1);
        rd(T_CAPVAL, rv); check("R8 rising capture", rv, 32'h1234);
        rd(T_FLAGS, rv);  check("R8 capture flag", rv, 32'h10);
        wr(T_COUNT, 32'h55);
        cap_in = 1'b0;
        idle(4);
        rd(T_CAPVAL, rv); check("R8 falling ignored", rv, 32'h1234);
        wr(T_CAPCTRL, 32'd2);
        wr(T_COUNT, 32'h77);
        cap_in = 1'b1;
        idle(4);
        rd(T_CAPVAL, rv); check("R8 rising ignored", rv, 32'h1234);
        cap_in = 1'b0;
        idle(4);
        rd(T_CAPVAL, rv); check("R8 falling capture", rv, 32'h77);
        wr(T_FLAGS, 32'h10);
        rd(T_FLAGS, rv);  check("R9 capture flag cleared", rv, 0);

        summary();
    end

endmodule